// File: doc/BRIEF.md
# Symbol-Rate Carrier Phase Tracker with Lock Quality

This block sits after symbol timing recovery in a phase-shift-keyed receiver. For each complex symbol it receives, it removes the current carrier phase estimate, takes hard decisions on the two rails, and derives a phase error from those decisions. The error drives a proportional-plus-integral loop filter. The filter output, together with a frequency word, advances a phase accumulator once per symbol.

While tracking is off, the accumulator stays frozen and samples pass through unrotated, so a differential demodulator downstream can use them. When acquisition completes, the measured frequency offset is written through the preload port and tracking is enabled. From then on the block follows the carrier coherently, one symbol at a time.

A leaky average of the error magnitude stands in for the phase-error variance. This average is reported as a quality level. It is also compared with a programmable threshold to give a lock flag.

Top module: `carrier_track`

## Requirements
- R1: After reset, `dec_valid` and `locked` are 0 and `quality` equals 2^(EW-1)-1, which is 127 with the defaults.
- R2: While `track_en` is 0, samples are not rotated (sector 0 is used), and the phase accumulator and integrator keep their values. A preload is the only exception.
- R3: The rotation sector is the top 3 bits of the PW-bit phase. With coefficient pairs (c,s) for sectors 0..7 of (64,0), (45,45), (0,64), (-45,45), (-64,0), (-45,-45), (0,-64), (45,-45), the rotated pair is I' = (I·c + Q·s) >>> 6 and Q' = (Q·c − I·s) >>> 6, each clamped to ±(2^(DW-1)-1).
- R4: One cycle after a cycle with `sym_valid` high, `dec_valid` is 1 and `dec_i`/`dec_q` are 1 exactly when the rotated I'/Q' are ≥ 0.
- R5: With `qpsk_mode`=1, `phase_err` = sgn(I')·Q' − sgn(Q')·I', where sgn(x) is +1 for x ≥ 0 and −1 otherwise. The result is clamped to ±(2^(EW-1)-1), so the most negative code never appears.
- R6: With `qpsk_mode`=0, `phase_err` = sgn(I')·Q', clamped in the same way.
- R7: On each valid symbol while tracking, phase ← phase + freq + (err >>> `kp_shift`) + integ and integ ← integ + (err >>> `ki_shift`), both modulo 2^PW. The integrator value used in the phase update is the one held before that symbol.
- R8: A `freq_load` pulse stores `freq_word` as the frequency and clears the phase and the integrator. It overrides the tracking update of the same cycle. A symbol in that cycle is still rotated with the old phase.
- R9: On every valid symbol, whether or not tracking is on, the average updates as avg ← avg − (avg >> LEAK) + |err|. `quality` = avg >> LEAK, where LEAK = 4 by default.
- R10: `locked` is 1 exactly when `quality` < `lock_thresh`.
- R11: A cycle with no `sym_valid` and no preload leaves `phase_err`, the decisions, the quality average and the phase unchanged, and `dec_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol present on sym_i/sym_q this cycle |
| sym_i | input | DW | In-phase symbol, signed |
| sym_q | input | DW | Quadrature symbol, signed |
| track_en | input | 1 | Enables de-rotation and loop updates |
| qpsk_mode | input | 1 | 1: four-phase error detector, 0: two-phase |
| kp_shift | input | SW | Right shift giving the proportional gain |
| ki_shift | input | SW | Right shift giving the integral gain |
| freq_load | input | 1 | Preload strobe |
| freq_word | input | PW | Frequency word taken on preload |
| lock_thresh | input | EW-1 | Lock threshold on quality |
| dec_valid | output | 1 | Decisions and error valid |
| dec_i | output | 1 | In-phase hard decision |
| dec_q | output | 1 | Quadrature hard decision |
| phase_err | output | EW | Signed phase error of the last symbol |
| quality | output | EW-1 | Averaged error magnitude |
| locked | output | 1 | Lock indication |

## Verification
Several properties are checked on every cycle:
- each symbol is followed by exactly one `dec_valid` pulse, and idle cycles change neither the error output, the average nor the phase;
- a preload clears the phase and the integrator;
- the phase is frozen while tracking is off;
- the error never reaches its most negative code;
- the average stays within its bound.

The bench scenarios are needed for everything numeric: the rotation table and clamps, both error detectors, the closed-loop phase and integrator trajectory under several gains, a preload that coincides with a symbol, and the point at which the lock flag rises as the average decays.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int UNITY      = 64;
  localparam int DIAG       = 45;
  localparam int COEF_SHIFT = 6;

  function automatic int coef_cos(input logic [2:0] sector);
    case (sector)
      3'd0:    return UNITY;
      3'd1:    return DIAG;
      3'd2:    return 0;
      3'd3:    return -DIAG;
      3'd4:    return -UNITY;
      3'd5:    return -DIAG;
      3'd6:    return 0;
      default: return DIAG;
    endcase
  endfunction

  // sine is cosine shifted back by a quarter turn (two sectors)
  function automatic int coef_sin(input logic [2:0] sector);
    logic [2:0] back;
    back = sector - 3'd2;
    return coef_cos(back);
  endfunction

  function automatic int clamp_sym(input int v, input int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int sgn(input int v);
    return (v >= 0) ? 1 : -1;
  endfunction

  function automatic int detect_err(input int ri, input int rq, input logic four_phase,
                                    input int lim);
    int raw;
    if (four_phase) raw = sgn(ri) * rq - sgn(rq) * ri;
    else            raw = sgn(ri) * rq;
    return clamp_sym(raw, lim);
  endfunction
endpackage

// File: rtl/ct_derotate.sv
module ct_derotate #(
  parameter int DW = 8
) (
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [2:0]           sector,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  import ct_pkg::*;
  localparam int LIM = (1 << (DW - 1)) - 1;

  always_comb begin
    int c, s, ai, aq;
    c  = coef_cos(sector);
    s  = coef_sin(sector);
    ai = (int'(in_i) * c + int'(in_q) * s) >>> COEF_SHIFT;
    aq = (int'(in_q) * c - int'(in_i) * s) >>> COEF_SHIFT;
    out_i = DW'(clamp_sym(ai, LIM));
    out_q = DW'(clamp_sym(aq, LIM));
  end

  always_comb begin
    assert_rot_in_range_R3: assert (out_i != {1'b1, {(DW-1){1'b0}}} &&
                                    out_q != {1'b1, {(DW-1){1'b0}}})
      else $error("rotated sample hit the excluded code");
  end
endmodule

// File: rtl/ct_loop_nco.sv
module ct_loop_nco #(
  parameter int PW = 12,
  parameter int EW = 8,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 load,
  input  logic [PW-1:0]        freq_word,
  input  logic [SW-1:0]        kp_shift,
  input  logic [SW-1:0]        ki_shift,
  input  logic signed [EW-1:0] err,
  output logic [2:0]           sector
);
  logic [PW-1:0]        freq_q, phase_q, integ_q;
  logic signed [PW-1:0] err_ext, prop_term, integ_inc;

  assign err_ext   = {{(PW-EW){err[EW-1]}}, err};
  assign prop_term = err_ext >>> kp_shift;
  assign integ_inc = err_ext >>> ki_shift;
  assign sector    = phase_q[PW-1 -: 3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q  <= '0;
      phase_q <= '0;
      integ_q <= '0;
    end else if (load) begin
      freq_q  <= freq_word;
      phase_q <= '0;
      integ_q <= '0;
    end else if (step) begin
      phase_q <= phase_q + freq_q + prop_term + integ_q;
      integ_q <= integ_q + integ_inc;
    end
  end

  assert_preload_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase_q == '0 && integ_q == '0))
    else $error("preload did not clear loop state");

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(phase_q) && $stable(integ_q) && $stable(freq_q)))
    else $error("loop state moved without an update");
endmodule

// File: rtl/ct_quality.sv
module ct_quality #(
  parameter int EW   = 8,
  parameter int LEAK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [EW-1:0] err,
  input  logic [EW-2:0]        thresh,
  output logic [EW-2:0]        quality,
  output logic                 locked
);
  localparam int AW = EW - 1 + LEAK;
  localparam logic [AW-1:0] AVG_MAX = AW'(((1 << (EW - 1)) - 1) << LEAK);

  logic [AW-1:0] avg_q, avg_next;
  logic [EW-1:0] neg_err;
  logic [EW-2:0] mag;

  assign neg_err  = -err;
  assign mag      = err[EW-1] ? neg_err[EW-2:0] : err[EW-2:0];
  assign avg_next = avg_q - (avg_q >> LEAK) + AW'(mag);
  assign quality  = avg_q[AW-1:LEAK];
  assign locked   = quality < thresh;

  always_ff @(posedge clk) begin
    if (!rst_n)   avg_q <= AVG_MAX;
    else if (upd) avg_q <= avg_next;
  end

  assert_avg_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    avg_q <= AVG_MAX)
    else $error("quality average beyond its bound");

  assert_avg_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(avg_q))
    else $error("quality average moved with no symbol");
endmodule

// File: rtl/carrier_track.sv
module carrier_track #(
  parameter int DW   = 8,
  parameter int EW   = 8,
  parameter int PW   = 12,
  parameter int SW   = 4,
  parameter int LEAK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_valid,
  input  logic signed [DW-1:0] sym_i,
  input  logic signed [DW-1:0] sym_q,
  input  logic                 track_en,
  input  logic                 qpsk_mode,
  input  logic [SW-1:0]        kp_shift,
  input  logic [SW-1:0]        ki_shift,
  input  logic                 freq_load,
  input  logic [PW-1:0]        freq_word,
  input  logic [EW-2:0]        lock_thresh,
  output logic                 dec_valid,
  output logic                 dec_i,
  output logic                 dec_q,
  output logic signed [EW-1:0] phase_err,
  output logic [EW-2:0]        quality,
  output logic                 locked
);
  import ct_pkg::*;
  localparam int ELIM = (1 << (EW - 1)) - 1;

  logic [2:0]           nco_sector, use_sector;
  logic signed [DW-1:0] rot_i, rot_q;
  logic signed [EW-1:0] err_now;
  logic                 loop_step;

  assign use_sector = track_en ? nco_sector : 3'd0;
  assign loop_step  = sym_valid && track_en;
  assign err_now    = EW'(detect_err(int'(rot_i), int'(rot_q), qpsk_mode, ELIM));

  ct_derotate #(.DW(DW)) u_rot (
    .in_i(sym_i), .in_q(sym_q), .sector(use_sector), .out_i(rot_i), .out_q(rot_q)
  );

  ct_loop_nco #(.PW(PW), .EW(EW), .SW(SW)) u_loop (
    .clk(clk), .rst_n(rst_n), .step(loop_step), .load(freq_load),
    .freq_word(freq_word), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .err(err_now), .sector(nco_sector)
  );

  ct_quality #(.EW(EW), .LEAK(LEAK)) u_qual (
    .clk(clk), .rst_n(rst_n), .upd(sym_valid), .err(err_now),
    .thresh(lock_thresh), .quality(quality), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_i     <= 1'b0;
      dec_q     <= 1'b0;
      phase_err <= '0;
    end else begin
      dec_valid <= sym_valid;
      if (sym_valid) begin
        dec_i     <= ~rot_i[DW-1];
        dec_q     <= ~rot_q[DW-1];
        phase_err <= err_now;
      end
    end
  end

  assert_dec_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> dec_valid)
    else $error("symbol without decision strobe");

  assert_no_stray_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> (!dec_valid && $stable(phase_err) && $stable(dec_i) && $stable(dec_q)))
    else $error("outputs moved with no symbol");

  assert_err_symmetric_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err != {1'b1, {(EW-1){1'b0}}})
    else $error("phase error reached the excluded code");

  assert_frozen_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!track_en && !freq_load) |=> $stable(nco_sector))
    else $error("sector moved while tracking is off");
endmodule

// File: tb/sim_carrier_track.sv
module sim_carrier_track;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 150000;
  localparam int LIM        = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic signed [7:0] sym_i = '0, sym_q = '0;
  logic track_en = 1'b0, qpsk_mode = 1'b1, freq_load = 1'b0;
  logic [3:0] kp_shift = 4'd2, ki_shift = 4'd5;
  logic [11:0] freq_word = '0;
  logic [6:0] lock_thresh = 7'd40;
  logic dec_valid, dec_i, dec_q, locked;
  logic signed [7:0] phase_err;
  logic [6:0] quality;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  int m_phase = 0, m_integ = 0, m_freq = 0, m_avg = 127 * 16;

  carrier_track u0 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .track_en(track_en), .qpsk_mode(qpsk_mode), .kp_shift(kp_shift),
    .ki_shift(ki_shift), .freq_load(freq_load), .freq_word(freq_word),
    .lock_thresh(lock_thresh), .dec_valid(dec_valid), .dec_i(dec_i), .dec_q(dec_q),
    .phase_err(phase_err), .quality(quality), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
  endfunction

  // quarter-turn table restated from R3
  function automatic int tcos(input int k);
    if (k == 0) return 64;
    if (k == 4) return -64;
    if (k == 2 || k == 6) return 0;
    if (k == 1 || k == 7) return 45;
    return -45;
  endfunction

  function automatic int sg(input int v);
    return v < 0 ? -1 : 1;
  endfunction

  task automatic do_sym(input int si, input int sq, input bit with_load, input int fw);
    int k, c, s, yi, yq, e, mag;
    k  = track_en ? ((m_phase >> 9) & 7) : 0;
    c  = tcos(k);
    s  = tcos((k + 6) & 7);
    yi = clampv((si * c + sq * s) >>> 6);
    yq = clampv((sq * c - si * s) >>> 6);
    e  = qpsk_mode ? clampv(sg(yi) * yq - sg(yq) * yi) : clampv(sg(yi) * yq);
    @(negedge clk);
    sym_valid = 1'b1; sym_i = 8'(si); sym_q = 8'(sq);
    freq_load = with_load; freq_word = 12'(fw);
    @(negedge clk);
    sym_valid = 1'b0; freq_load = 1'b0;
    if (with_load) begin
      m_freq = fw; m_phase = 0; m_integ = 0;
    end else if (track_en) begin
      m_phase = (m_phase + m_freq + (e >>> kp_shift) + m_integ) & 12'hfff;
      m_integ = (m_integ + (e >>> ki_shift)) & 12'hfff;
    end
    mag = e < 0 ? -e : e;
    m_avg = m_avg - (m_avg >> 4) + mag;
    chk(dec_valid == 1'b1, "R4 strobe", int'(dec_valid), 1);
    chk(dec_i == (yi >= 0) && dec_q == (yq >= 0), "R3/R4 decisions",
        int'({dec_i, dec_q}), int'({yi >= 0, yq >= 0}));
    chk(int'(phase_err) == e, qpsk_mode ? "R5 error" : "R6 error", int'(phase_err), e);
    chk(int'(quality) == (m_avg >> 4), "R9 quality", int'(quality), m_avg >> 4);
    chk(locked == ((m_avg >> 4) < int'(lock_thresh)), "R10 lock",
        int'(locked), int'((m_avg >> 4) < int'(lock_thresh)));
  endtask

  task automatic do_load(input int fw);
    @(negedge clk);
    freq_load = 1'b1; freq_word = 12'(fw);
    @(negedge clk);
    freq_load = 1'b0;
    m_freq = fw; m_phase = 0; m_integ = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid == 1'b0, "R1 dec_valid", int'(dec_valid), 0);
    chk(quality == 7'd127, "R1 quality", int'(quality), 127);
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);

    // R2: tracking off, frequency loaded; no rotation, loop frozen
    do_load(300);
    track_en = 1'b0;
    for (int mode = 1; mode >= 0; mode--) begin
      qpsk_mode = mode[0];
      for (int a = -128; a < 128; a += 15)
        for (int b = -128; b < 128; b += 15)
          do_sym(a, b, 1'b0, 0);
    end

    // R11: idle cycles change nothing
    begin
      int pe, ql;
      pe = int'(phase_err); ql = int'(quality);
      for (int n = 0; n < 5; n++) begin
        @(negedge clk);
        chk(dec_valid == 1'b0 && int'(phase_err) == pe && int'(quality) == ql,
            "R11 idle hold", int'(phase_err), pe);
      end
    end

    // R7/R3: closed loop from frozen state, several gains and both detectors
    track_en = 1'b1;
    for (int g = 0; g < 4; g++) begin
      kp_shift = 4'(1 + g); ki_shift = 4'(3 + g); qpsk_mode = g[0];
      for (int n = 0; n < 150; n++)
        do_sym(((n * 37) % 200) - 100, ((n * 53 + 11) % 180) - 90, 1'b0, 0);
    end

    // R8: preload coinciding with a symbol, then continue tracking
    qpsk_mode = 1'b1; kp_shift = 4'd2; ki_shift = 4'd4;
    do_sym(70, -30, 1'b1, 1500);
    for (int n = 0; n < 60; n++) do_sym(40, 90 - n, 1'b0, 0);

    // R10: clean constellation point at phase zero, lock must rise
    lock_thresh = 7'd10;
    do_load(0);
    for (int n = 0; n < 120; n++) do_sym(60, 60, 1'b0, 0);
    chk(locked == 1'b1, "R10 lock reached", int'(locked), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule